// File: doc/BRIEF.md
# Three-Channel Timer Register Decoder

This block is the top level of a small timer peripheral. It sits behind a plain read/write strobe interface and decodes a 0x30-byte register window. The window holds two shared registers and three channel windows. The first shared register is a one-bit output-control latch that drives a pin. The second is a run-gate register, and each of its low three bits starts or stops one channel. Each channel window is routed to a down-counting channel, and the offset is rebased to the start of that window.

Each channel has a reload value, a running count, a control word (prescaler code, interrupt enable, underflow flag) and its own interrupt line. Only the third channel has an extra capture-value register that software can read and write. A build option removes the third channel and the output-control register. In that build, their addresses become unmapped, and a write that tries to start the missing channel is reported.

Read data is combinational from the registers. Any access that misses the map raises a one-cycle error pulse on the following cycle.

Top module: `tmr_unit`

## Requirements
- R1: Byte offsets decode by word (address bits [1:0] ignored). 0x00 is the output-control register, which keeps only bit 0 and drives `oc_out`; 0x04 is the run-gate register; the channel windows start at 0x08, 0x14 and 0x20 and are matched by comparing against 0x20 first, then 0x14, then 0x08. Within a window, rebased word 0 is reload, 1 is count, 2 is control, 3 is capture.
- R2: Run-gate bits 0, 1 and 2 run (1) or stop (0) channels 0, 1 and 2. The whole written value is stored and reads back unchanged. A stopped channel holds its count.
- R3: A running channel's prescaler divides the clock by 4, 16, 64, 256 or 1024 for control[2:0] codes 0 to 4; codes 5 to 7 divide by 1024. Each prescaled tick decrements the count. A tick at count 0 reloads the count from reload and sets the underflow flag at control bit 8.
- R4: `irq[i]` equals channel i's underflow flag AND its enable at control bit 5. A control write with bit 8 clear clears the flag; with bit 8 set the flag is kept. An underflow in the same cycle as a clearing write leaves the flag set.
- R5: A count write takes effect over a tick in the same cycle. A control write restarts the prescaler from zero.
- R6: An unmapped access reads 0 and its write changes nothing. Unmapped means offsets 0x30 and above in every build; in the reduced build it also means 0x00–0x03 and 0x20–0x2F.
- R7: `err` is high for the cycle after any unmapped access, and also after a run-gate write with bit 2 set when the third channel is absent. It is low after any cycle without such an access.
- R8: Reset (synchronous, active high) clears the run-gate, output-control, control, flag and capture registers, and sets reload and count to all ones.
- R9: The third channel's capture register at offset 0x2C reads back the last value written to it.
- R10: Without the third channel, run-gate bit 2 starts nothing and `irq[2]` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte offset into the window |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational |
| irq | output | 3 | One interrupt per channel |
| oc_out | output | 1 | Output-control bit |
| err | output | 1 | One-cycle pulse after a bad access |

## Verification
A wrong count, prescaler phase or flag inside a channel first shows on `irq` at the cycle where the model and the design disagree about an underflow. It shows sooner if the bench reads the count word, because read data is combinational. A misrouted channel window shows at once: the next read returns another channel's state. A stale run-gate bit shows within one prescaler period as a count that moves or freezes when it should not. The per-clock comparison of `irq`, `err` and `oc_out` catches an error pulse that comes one cycle early or late.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCH       = 3;
    localparam int BASE_CH0  = 8;
    localparam int BASE_CH1  = 20;
    localparam int BASE_CH2  = 32;
    localparam int WIN_END   = 48;
    localparam int PRE_W     = 10;
    localparam int BIT_IE    = 5;
    localparam int BIT_FLG   = 8;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_OCTL,
        TGT_START,
        TGT_CH0,
        TGT_CH1,
        TGT_CH2
    } tgt_e;

    typedef struct packed {
        tgt_e       tgt;
        logic [1:0] word;
    } dec_t;

    typedef enum logic [1:0] {
        CW_RELOAD = 2'd0,
        CW_COUNT  = 2'd1,
        CW_CTRL   = 2'd2,
        CW_CAPT   = 2'd3
    } cword_e;

    typedef struct packed {
        logic       ie;
        logic [2:0] psel;
    } ctl_t;

    // Last prescaler value before a tick for each divider code.
    function automatic logic [PRE_W-1:0] pre_last(input logic [2:0] psel);
        case (psel)
            3'd0:    return PRE_W'(3);
            3'd1:    return PRE_W'(15);
            3'd2:    return PRE_W'(63);
            3'd3:    return PRE_W'(255);
            default: return PRE_W'(1023);
        endcase
    endfunction

    function automatic tgt_e chan_tgt(input int i);
        case (i)
            0:       return TGT_CH0;
            1:       return TGT_CH1;
            default: return TGT_CH2;
        endcase
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int AW       = 6,
    parameter bit HAS_CH2  = 1'b1,
    parameter bit HAS_OCTL = 1'b1
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec
);

    localparam logic [AW-1:0] B0 = AW'(BASE_CH0);
    localparam logic [AW-1:0] B1 = AW'(BASE_CH1);
    localparam logic [AW-1:0] B2 = AW'(BASE_CH2);
    localparam logic [AW-1:0] BE = AW'(WIN_END);

    logic [AW-1:0] rebased;

    // Descending comparison: highest window first, then rebase.
    always_comb begin
        dec.tgt  = TGT_NONE;
        dec.word = 2'd0;
        rebased  = '0;
        if (addr >= B2) begin
            rebased = addr - B2;
            if (HAS_CH2 && addr < BE) begin
                dec.tgt  = TGT_CH2;
                dec.word = rebased[3:2];
            end
        end else if (addr >= B1) begin
            rebased  = addr - B1;
            dec.tgt  = TGT_CH1;
            dec.word = rebased[3:2];
        end else if (addr >= B0) begin
            rebased  = addr - B0;
            dec.tgt  = TGT_CH0;
            dec.word = rebased[3:2];
        end else if (addr[AW-1:2] == (AW-2)'(1)) begin
            dec.tgt = TGT_START;
        end else if (HAS_OCTL) begin
            dec.tgt = TGT_OCTL;
        end
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int DW   = 32,
    parameter bit CAPT = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          acc_wr,
    input  logic [1:0]    word,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);

    logic [DW-1:0]    reload_q;
    logic [DW-1:0]    count_q;
    logic [DW-1:0]    cap_q;
    logic [DW-1:0]    ctrl_rd;
    ctl_t             ctl_q;
    logic             flag_q;
    logic [PRE_W-1:0] pre_q;
    logic             wr_reload, wr_count, wr_ctrl;
    logic             tick, under;

    assign wr_reload = acc_wr && (word == CW_RELOAD);
    assign wr_count  = acc_wr && (word == CW_COUNT);
    assign wr_ctrl   = acc_wr && (word == CW_CTRL);

    assign tick  = run && (pre_q == pre_last(ctl_q.psel));
    assign under = tick && (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '1;
            count_q  <= '1;
            ctl_q    <= '0;
            flag_q   <= 1'b0;
            pre_q    <= '0;
        end else begin
            if (wr_ctrl || !run || tick)
                pre_q <= '0;
            else
                pre_q <= pre_q + 1'b1;

            if (wr_count)
                count_q <= wdata;
            else if (tick)
                count_q <= under ? reload_q : count_q - 1'b1;

            if (wr_reload)
                reload_q <= wdata;

            if (wr_ctrl)
                ctl_q <= '{ie: wdata[BIT_IE], psel: wdata[2:0]};

            if (under)
                flag_q <= 1'b1;
            else if (wr_ctrl && !wdata[BIT_FLG])
                flag_q <= 1'b0;
        end
    end

    generate
        if (CAPT) begin : g_capt
            logic wr_capt;
            assign wr_capt = acc_wr && (word == CW_CAPT);
            always_ff @(posedge clk) begin
                if (rst)
                    cap_q <= '0;
                else if (wr_capt)
                    cap_q <= wdata;
            end
        end else begin : g_nocapt
            assign cap_q = '0;
        end
    endgenerate

    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[2:0]     = ctl_q.psel;
        ctrl_rd[BIT_IE]  = ctl_q.ie;
        ctrl_rd[BIT_FLG] = flag_q;
    end

    always_comb begin
        case (cword_e'(word))
            CW_RELOAD: rdata = reload_q;
            CW_COUNT:  rdata = count_q;
            CW_CTRL:   rdata = ctrl_rd;
            default:   rdata = cap_q;
        endcase
    end

    assign irq = flag_q & ctl_q.ie;

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int AW       = 6,
    parameter int DW       = 32,
    parameter bit HAS_CH2  = 1'b1,
    parameter bit HAS_OCTL = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [2:0]    irq,
    output logic          oc_out,
    output logic          err
);

    dec_t          dec;
    logic [DW-1:0] start_q;
    logic          oc_q;
    logic          err_q;
    logic          bad;
    logic [DW-1:0] ch_rdata [NCH];

    tmr_decode #(
        .AW      (AW),
        .HAS_CH2 (HAS_CH2),
        .HAS_OCTL(HAS_OCTL)
    ) u_dec (
        .addr(bus_addr),
        .dec (dec)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            if (i < 2 || HAS_CH2) begin : g_on
                tmr_chan #(
                    .DW  (DW),
                    .CAPT(i == 2)
                ) u_ch (
                    .clk   (clk),
                    .rst   (rst),
                    .run   (start_q[i]),
                    .acc_wr(bus_wr && dec.tgt == chan_tgt(i)),
                    .word  (dec.word),
                    .wdata (bus_wdata),
                    .rdata (ch_rdata[i]),
                    .irq   (irq[i])
                );
            end else begin : g_off
                assign ch_rdata[i] = '0;
                assign irq[i]      = 1'b0;
            end
        end
    endgenerate

    assign bad = ((bus_wr || bus_rd) && dec.tgt == TGT_NONE) ||
                 (!HAS_CH2 && bus_wr && dec.tgt == TGT_START && bus_wdata[2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            oc_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= bad;
            if (bus_wr && dec.tgt == TGT_START)
                start_q <= bus_wdata;
            if (bus_wr && dec.tgt == TGT_OCTL)
                oc_q <= bus_wdata[0];
        end
    end

    always_comb begin
        case (dec.tgt)
            TGT_OCTL:  bus_rdata = {{(DW-1){1'b0}}, oc_q};
            TGT_START: bus_rdata = start_q;
            TGT_CH0:   bus_rdata = ch_rdata[0];
            TGT_CH1:   bus_rdata = ch_rdata[1];
            TGT_CH2:   bus_rdata = ch_rdata[2];
            default:   bus_rdata = '0;
        endcase
    end

    assign oc_out = oc_q;
    assign err    = err_q;

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
    import tmr_pkg::*;
#(
    parameter int AW       = 6,
    parameter int DW       = 32,
    parameter bit HAS_CH2  = 1'b1,
    parameter bit HAS_OCTL = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [2:0]    irq,
    input logic          oc_out,
    input logic          err,
    input logic [DW-1:0] start_q
);

    localparam logic [AW-1:0] ENDA = AW'(WIN_END);

    logic hit_start, hit_oc;
    assign hit_start = bus_addr[AW-1:2] == (AW-2)'(1);
    assign hit_oc    = bus_addr[AW-1:2] == '0;

    a_r6_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr >= ENDA) |-> (bus_rdata == '0));

    a_r7_err_after_unmapped: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && bus_addr >= ENDA) |=> err);

    a_r7_err_needs_access: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr || bus_rd) |=> !err);

    a_r2_start_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit_start) |=> (start_q == $past(bus_wdata)));

    a_r1_oc_follows_write: assert property (@(posedge clk) disable iff (rst)
        (HAS_OCTL && bus_wr && hit_oc) |=> (oc_out == $past(bus_wdata[0])));

    a_r4_irq0_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && !start_q[0]) |=> $stable(irq[0]));

    a_r4_irq1_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && !start_q[1]) |=> $stable(irq[1]));

    a_r10_bit2_flagged: assert property (@(posedge clk) disable iff (rst)
        (!HAS_CH2 && bus_wr && hit_start && bus_wdata[2]) |=> err);

endmodule

bind tmr_unit tmr_unit_chk #(
    .AW      (AW),
    .DW      (DW),
    .HAS_CH2 (HAS_CH2),
    .HAS_OCTL(HAS_OCTL)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .oc_out   (oc_out),
    .err      (err),
    .start_q  (start_q)
);

// File: tb/tmr_unit_test.sv
`timescale 1ns/1ps
module tmr_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, l_rdata;
    logic [2:0]  irq, l_irq;
    logic        oc_out, l_oc, err, l_err;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    always #2 clk = ~clk;

    tmr_unit uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .oc_out(oc_out), .err(err)
    );

    tmr_unit #(.HAS_CH2(1'b0), .HAS_OCTL(1'b0)) uut_lite (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(l_rdata),
        .irq(l_irq), .oc_out(l_oc), .err(l_err)
    );

    // ---------------- behavioural reference model (full build) ----------
    logic [31:0] m_rel [3];
    logic [31:0] m_cnt [3];
    logic [2:0]  m_sel [3];
    bit          m_ie  [3];
    bit          m_flg [3];
    int          m_pre [3];
    logic [31:0] m_cap, m_start;
    bit          m_oc, m_err;

    // kind: 0 none, 1 output-control, 2 run-gate, 3 channel
    function automatic int m_decode(input logic [5:0] a, output int ch, output int w);
        int o = int'(a);
        ch = 0; w = 0;
        if (o >= 48) return 0;
        if (o >= 32) begin ch = 2; w = (o - 32) / 4; return 3; end
        if (o >= 20) begin ch = 1; w = (o - 20) / 4; return 3; end
        if (o >= 8)  begin ch = 0; w = (o - 8) / 4;  return 3; end
        if (o >= 4)  return 2;
        return 1;
    endfunction

    function automatic int m_last(input logic [2:0] s);
        if (s >= 3'd4) return 1023;
        return (4 << (2 * int'(s))) - 1;
    endfunction

    function automatic logic [31:0] m_read(input logic [5:0] a);
        int ch, w, k;
        k = m_decode(a, ch, w);
        case (k)
            1: return {31'd0, m_oc};
            2: return m_start;
            3: case (w)
                   0: return m_rel[ch];
                   1: return m_cnt[ch];
                   2: return (32'(m_flg[ch]) << 8) | (32'(m_ie[ch]) << 5) | 32'(m_sel[ch]);
                   default: return (ch == 2) ? m_cap : 32'd0;
               endcase
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                m_rel[i] = '1; m_cnt[i] = '1; m_sel[i] = '0;
                m_ie[i] = 0; m_flg[i] = 0; m_pre[i] = 0;
            end
            m_cap = '0; m_start = '0; m_oc = 0; m_err = 0;
        end else begin
            int ch, w, k;
            k = m_decode(bus_addr, ch, w);
            for (int i = 0; i < 3; i++) begin
                bit run, tk, und, cw;
                run = m_start[i];
                tk  = run && (m_pre[i] == m_last(m_sel[i]));
                und = tk && (m_cnt[i] == 0);
                cw  = bus_wr && k == 3 && ch == i && w == 2;
                if (!run || tk || cw) m_pre[i] = 0; else m_pre[i]++;
                if (bus_wr && k == 3 && ch == i && w == 1) m_cnt[i] = bus_wdata;
                else if (tk) m_cnt[i] = und ? m_rel[i] : m_cnt[i] - 1;
                if (bus_wr && k == 3 && ch == i && w == 0) m_rel[i] = bus_wdata;
                if (und) m_flg[i] = 1;
                else if (cw && !bus_wdata[8]) m_flg[i] = 0;
                if (cw) begin m_sel[i] = bus_wdata[2:0]; m_ie[i] = bus_wdata[5]; end
                if (bus_wr && k == 3 && ch == 2 && i == 2 && w == 3) m_cap = bus_wdata;
            end
            if (bus_wr && k == 2) m_start = bus_wdata;
            if (bus_wr && k == 1) m_oc = bus_wdata[0];
            m_err = (bus_wr || bus_rd) && k == 0;
        end
    end

    // per-clock comparison of registered outputs (R4 irq, R7 err, R1 oc)
    always @(negedge clk) begin
        if (!rst) begin
            logic [2:0] ei;
            ei = {m_flg[2] & m_ie[2], m_flg[1] & m_ie[1], m_flg[0] & m_ie[0]};
            vectors++;
            if (irq !== ei || err !== m_err || oc_out !== m_oc) begin
                fails++;
                $display("FAIL R4 R7 R1 irq/err/oc act=%b/%b/%b exp=%b/%b/%b at cycle %0d",
                         irq, err, oc_out, ei, m_err, m_oc, cyc);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // ---------------- stimulus tasks -------------------------------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 chk(tag, bus_rdata, m_read(a));
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic rd_lite(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 chk(tag, l_rdata, exp);
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // ---------------- test sequence --------------------------------------
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R8 reset values
        rd(6'h00, "R8 oc reset");
        rd(6'h04, "R8 start reset");
        rd(6'h08, "R8 reload reset");
        rd(6'h0C, "R8 count reset");
        rd(6'h10, "R8 control reset");
        rd(6'h2C, "R8 capture reset");
        @(negedge clk) chk("R8 irq reset", {29'd0, irq}, 32'd0);

        // R1 output-control keeps bit 0; low address bits ignored
        wr(6'h00, 32'hFFFF_FFFE);
        rd(6'h00, "R1 oc bit0 clear");
        wr(6'h02, 32'h0000_0003);
        rd(6'h01, "R1 oc bit0 set");
        wr(6'h04, 32'h0);
        rd(6'h07, "R1 start alias");

        // R3 channel 0, divide by 4, enable irq
        wr(6'h08, 32'd3);
        wr(6'h0C, 32'd3);
        wr(6'h10, 32'h20);
        wr(6'h04, 32'h1);
        for (int n = 0; n < 12; n++) begin
            rd(6'h0C, "R3 ch0 count");
            idle(2);
        end
        rd(6'h10, "R3 ch0 flag");

        // R4 keep-flag write, then clear, then disable
        wr(6'h10, 32'h120);
        rd(6'h10, "R4 flag kept");
        wr(6'h10, 32'h020);
        rd(6'h10, "R4 flag cleared");
        idle(30);
        wr(6'h10, 32'h000);
        idle(20);
        rd(6'h10, "R4 flag with irq off");

        // R3 channel 1, divide by 16
        wr(6'h14, 32'd2);
        wr(6'h18, 32'd5);
        wr(6'h1C, 32'h21);
        wr(6'h04, 32'h3);
        for (int n = 0; n < 20; n++) begin
            rd(6'h18, "R3 ch1 count");
            idle(9);
        end

        // R3 channel 2, reserved code 7 acts as divide by 1024
        wr(6'h20, 32'd0);
        wr(6'h24, 32'd0);
        wr(6'h28, 32'h27);
        wr(6'h04, 32'h7);
        idle(1010);
        rd(6'h28, "R3 ch2 before tick");
        idle(30);
        rd(6'h28, "R3 ch2 after tick");
        rd(6'h24, "R3 ch2 count");

        // R5 count write over running count, control write restarts prescaler
        wr(6'h0C, 32'h100);
        rd(6'h0C, "R5 count written");
        wr(6'h10, 32'h21);
        idle(3);
        rd(6'h0C, "R5 prescaler restart");
        idle(5);
        rd(6'h0C, "R5 after restart");

        // R9 capture register
        wr(6'h2C, 32'hA5A5_0F0F);
        rd(6'h2C, "R9 capture readback");
        rd(6'h2D, "R9 capture alias");

        // R6 R7 unmapped window
        rd(6'h30, "R6 unmapped read");
        @(negedge clk) chk("R7 err after read", {31'd0, err}, 32'd1);
        wr(6'h34, 32'hFFFF_FFFF);
        @(negedge clk) chk("R7 err after write", {31'd0, err}, 32'd1);
        rd(6'h3C, "R6 unmapped read high");
        rd(6'h08, "R6 reload untouched");
        rd(6'h04, "R6 start untouched");
        idle(2);
        @(negedge clk) chk("R7 err idle", {31'd0, err}, 32'd0);

        // R2 whole value stored, all channels stopped by bits 0..2 clear
        wr(6'h04, 32'hDEAD_BEE0);
        rd(6'h04, "R2 start readback");
        rd(6'h0C, "R2 ch0 held");
        idle(40);
        rd(6'h0C, "R2 ch0 still held");
        rd(6'h18, "R2 ch1 held");

        // R10 R6 R7 on the reduced build
        wr(6'h04, 32'h7);
        @(negedge clk) chk("R10 bit2 flagged", {31'd0, l_err}, 32'd1);
        rd_lite(6'h04, 32'h7, "R2 lite start readback");
        rd_lite(6'h00, 32'h0, "R6 lite oc unmapped");
        @(negedge clk) chk("R7 lite err on oc", {31'd0, l_err}, 32'd1);
        wr(6'h24, 32'h0);
        wr(6'h28, 32'h20);
        rd_lite(6'h24, 32'h0, "R6 lite ch2 unmapped");
        idle(1100);
        @(negedge clk) chk("R10 lite irq2 low", {31'd0, l_irq[2]}, 32'd0);
        chk("R1 lite oc low", {31'd0, l_oc}, 32'd0);
        wr(6'h04, 32'h3);
        @(negedge clk) chk("R10 no flag without bit2", {31'd0, l_err}, 32'd0);

        idle(4);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule